// File: doc/BRIEF.md
# Dual-Phase Serial Audio Transceiver

This block moves audio words between a parallel word interface and a serial data line, keeping time with an external bit tick and frame sync. Every data bit occupies one `bit_tick` cycle. The block shifts the transmit word out MSB first on `sdout` and shifts `sdin` into a receive register on the same ticks. It then presents each finished receive word in parallel with a one-cycle valid pulse. It does not generate clocks and does not hold a FIFO. The transmit side takes one word per slot through a valid/ready pair, and the receive side produces one word per slot.

A frame has one of two shapes. In the single-phase shape, a rising frame-sync edge starts a run of back-to-back words, one per channel. In the dual-phase shape, used for two-channel I2S and left-justified streams, the rising edge starts a one-word first phase and the falling edge starts a one-word second phase. The interface format selects the data delay, meaning whether the first bit lands on the edge tick or on the tick after it. The format also selects whether received words are sign extended. A sticky flag records a missing transmit word. Another sticky flag records a sync edge that cut a frame short.

Top module: `sat_transceiver`

## Requirements
- R1: `cfg_wlen` selects the word length: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32 bits, and codes 6 and 7 also give 32 bits.
- R2: A transmit word is taken from the low W bits of `tx_data`, and bits above W are ignored. It is sent MSB first, one bit per tick. `sdout` changes on the clock edge at which `bit_tick` is high.
- R3: `cfg_format` is 0=I2S, 1=left-justified, 2=DSP-A, 3=DSP-B. For I2S and DSP-A, the first data bit falls on the tick after the starting sync edge. For left-justified and DSP-B, it falls on the edge tick itself.
- R4: In single-phase mode, a rising sync edge (sampled on ticks) starts `cfg_words_m1`+1 words that follow each other with no gap.
- R5: Dual-phase mode applies only when the format is I2S or left-justified and `cfg_words_m1` is 1. The rising edge starts one word and the falling edge starts one word. In every other case, falling edges are ignored.
- R6: `sdin` is captured on every data-bit tick, MSB first. `rx_valid` is high for exactly one clock after the tick carrying a word's last bit. `rx_data` then holds the word right-justified, with the upper bits zero, or copies of the word MSB in left-justified format.
- R7: `tx_ready` is high only in the clock of a tick that carries the first bit of a slot. A word moves when `tx_valid` is also high.
- R8: If `tx_valid` is low when a slot starts, the whole slot is sent as zeros and the sticky `underrun` flag is set.
- R9: A sync edge that arrives before the frame or phase has finished sets the sticky `frame_err` and restarts framing from that edge, dropping the partial word. In a 1-bit-delay format, an edge during the final bit is legal. An edge on the tick after the final bit is legal in every format.
- R10: Outside data slots, `sdout` is driven low.
- R11: After reset, `sdout`, `rx_valid`, `rx_data`, `underrun` and `frame_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| fsync | input | 1 | Frame sync level, sampled on ticks |
| sdin | input | 1 | Serial receive data, sampled on ticks |
| cfg_format | input | 2 | Interface format (R3) |
| cfg_wlen | input | 3 | Encoded word length (R1) |
| cfg_words_m1 | input | FRAME_W | Words per frame minus one |
| tx_data | input | DATA_W | Transmit word, right-justified |
| tx_valid | input | 1 | Transmit word present |
| tx_ready | output | 1 | Transmit word taken this clock |
| sdout | output | 1 | Serial transmit data |
| rx_data | output | DATA_W | Received word |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| underrun | output | 1 | Sticky missing-word flag |
| frame_err | output | 1 | Sticky early-sync flag |

## Verification
A four-word DSP-B frame with a one-tick sync pulse checks back-to-back slot chaining and the 0-bit delay. Paired DSP-A frames, with the second edge on the tick right after the last bit, separate a legal frame boundary from an early one. Two I2S stereo frames place the phase edge inside the final bit of each phase. A left-justified stereo frame with negative and positive samples separates sign extension from zero fill. A three-channel I2S frame that drops sync halfway shows that falling edges are ignored outside dual-phase mode, and short frames with an empty transmit queue and with a premature second edge cover the underrun and restart paths.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;

   typedef enum logic [1:0] {
      FMT_I2S   = 2'd0,
      FMT_LEFTJ = 2'd1,
      FMT_DSPA  = 2'd2,
      FMT_DSPB  = 2'd3
   } sat_fmt_e;

   // Encoded word length to bit count; unused codes fall back to the widest.
   function automatic logic [5:0] wlen_to_bits(input logic [2:0] code);
      case (code)
         3'd0:    return 6'd8;
         3'd1:    return 6'd12;
         3'd2:    return 6'd16;
         3'd3:    return 6'd20;
         3'd4:    return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

   function automatic logic fmt_has_delay(input sat_fmt_e f);
      return (f == FMT_I2S) || (f == FMT_DSPA);
   endfunction

   function automatic logic fmt_stereo_capable(input sat_fmt_e f);
      return (f == FMT_I2S) || (f == FMT_LEFTJ);
   endfunction

endpackage

// File: rtl/sat_frame_seq.sv
`timescale 1ns/1ps
module sat_frame_seq #(
   parameter int BITS_W  = 6,
   parameter int FRAME_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               fsync,
   input  logic               dual,
   input  logic               dly,
   input  logic [BITS_W-1:0]  word_bits,
   input  logic [FRAME_W-1:0] words_m1,
   output logic               slot_go,
   output logic               bit_act,
   output logic               word_end,
   output logic [BITS_W-1:0]  bit_idx,
   output logic               frame_err
);

   logic               fs_q;
   logic               busy;
   logic               pend;
   logic [BITS_W-1:0]  bit_cnt;
   logic [FRAME_W-1:0] words_left;

   logic [BITS_W-1:0]  last_idx;
   logic               rise, fall, start_edge;
   logic               at_last, at_penult, no_more;
   logic               frame_done, frame_last, edge_ok;
   logic               cont_bit, next_word;

   assign last_idx   = word_bits - 1'b1;
   assign rise       = fsync & ~fs_q;
   assign fall       = ~fsync & fs_q & dual;
   assign start_edge = bit_tick & (rise | fall);

   assign at_last    = (bit_cnt == last_idx);
   assign at_penult  = (bit_cnt == last_idx - 1'b1);
   assign no_more    = (words_left == '0);

   // Frame over: nothing pending and the final word has sent its last bit.
   assign frame_done = ~pend & (~busy | (at_last & no_more));
   // This tick carries the final bit of the frame or phase.
   assign frame_last = busy & at_penult & no_more;
   // With a one-bit delay the next edge may coincide with the final bit.
   assign edge_ok    = frame_done | (dly & frame_last);

   assign cont_bit   = busy & ~at_last;
   assign next_word  = busy & at_last & ~no_more;

   assign slot_go  = bit_tick & (start_edge ? ~dly : (pend | next_word));
   assign bit_act  = bit_tick & (start_edge ? (~dly | frame_last)
                                            : (pend | cont_bit | next_word));
   assign bit_idx  = slot_go ? '0 : bit_cnt + 1'b1;
   assign word_end = bit_act & (bit_idx == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q       <= 1'b0;
         busy       <= 1'b0;
         pend       <= 1'b0;
         bit_cnt    <= '0;
         words_left <= '0;
         frame_err  <= 1'b0;
      end else if (bit_tick) begin
         fs_q <= fsync;
         if (start_edge) begin
            words_left <= dual ? '0 : words_m1;
            bit_cnt    <= '0;
            if (!edge_ok) frame_err <= 1'b1;
            pend <= dly;
            busy <= ~dly;
         end else if (pend) begin
            pend    <= 1'b0;
            busy    <= 1'b1;
            bit_cnt <= '0;
         end else if (busy) begin
            if (cont_bit) begin
               bit_cnt <= bit_cnt + 1'b1;
            end else if (next_word) begin
               bit_cnt    <= '0;
               words_left <= words_left - 1'b1;
            end else begin
               busy <= 1'b0;
            end
         end
      end
   end

   // R9: the early-sync flag never clears outside reset
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err) else $error("frame_err dropped");

   // R6: words are at least eight ticks long, so word ends never touch
   p_word_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_end |=> !word_end) else $error("adjacent word ends");

   // R3: a delayed format never starts a slot on the edge tick
   p_delay_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_edge && dly) |-> !slot_go) else $error("slot on delayed edge");

endmodule

// File: rtl/sat_tx_shift.sv
`timescale 1ns/1ps
module sat_tx_shift #(
   parameter int DATA_W = 32,
   parameter int BITS_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              slot_go,
   input  logic              bit_act,
   input  logic [BITS_W-1:0] bit_idx,
   input  logic [BITS_W-1:0] word_bits,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              sdout,
   output logic              underrun
);

   logic [DATA_W-1:0] sh_q;
   logic [BITS_W-1:0] last_idx, sel;
   logic [DATA_W-1:0] tx_shr, sh_shr;

   assign last_idx = word_bits - 1'b1;
   assign sel      = last_idx - bit_idx;
   assign tx_shr   = tx_data >> last_idx;
   assign sh_shr   = sh_q >> sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q     <= '0;
         sdout    <= 1'b0;
         underrun <= 1'b0;
      end else if (bit_tick) begin
         if (slot_go) begin
            sh_q  <= tx_valid ? tx_data : '0;
            sdout <= tx_valid & tx_shr[0];
            if (!tx_valid) underrun <= 1'b1;
         end else if (bit_act) begin
            sdout <= sh_shr[0];
         end else begin
            sdout <= 1'b0;
         end
      end
   end

   // R2: the serial line moves only on tick cycles
   p_sdout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(sdout)) else $error("sdout moved off tick");

   // R8: a slot started without data begins with a zero bit
   p_zero_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_go && !tx_valid) |=> (!sdout && underrun)) else $error("underrun slot not zero");

   // R8: the underrun flag is sticky
   p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun) else $error("underrun dropped");

endmodule

// File: rtl/sat_rx_shift.sv
`timescale 1ns/1ps
module sat_rx_shift #(
   parameter int DATA_W = 32,
   parameter int BITS_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_act,
   input  logic              word_end,
   input  logic              sdin,
   input  logic              sext,
   input  logic [BITS_W-1:0] word_bits,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);

   logic [DATA_W-1:0] sh_q, nxt, nxt_shr, ext;
   logic [BITS_W-1:0] last_idx;
   logic              fill;

   assign last_idx = word_bits - 1'b1;
   assign nxt      = {sh_q[DATA_W-2:0], sdin};
   assign nxt_shr  = nxt >> last_idx;
   assign fill     = sext & nxt_shr[0];

   for (genvar g = 0; g < DATA_W; g++) begin : g_ext
      assign ext[g] = (BITS_W'(g) < word_bits) ? nxt[g] : fill;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q     <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= word_end;
         if (bit_act)  sh_q    <= nxt;
         if (word_end) rx_data <= ext;
      end
   end

   // R6: the received-word strobe lasts a single clock
   p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid) else $error("rx_valid held");

   // R6: without sign extension nothing lands above the word
   p_rx_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !sext) |-> ((rx_data >> word_bits) == '0)) else $error("rx upper bits set");

endmodule

// File: rtl/sat_transceiver.sv
`timescale 1ns/1ps
module sat_transceiver #(
   parameter int DATA_W  = 32,
   parameter int FRAME_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               fsync,
   input  logic               sdin,
   input  logic [1:0]         cfg_format,
   input  logic [2:0]         cfg_wlen,
   input  logic [FRAME_W-1:0] cfg_words_m1,
   input  logic [DATA_W-1:0]  tx_data,
   input  logic               tx_valid,
   output logic               tx_ready,
   output logic               sdout,
   output logic [DATA_W-1:0]  rx_data,
   output logic               rx_valid,
   output logic               underrun,
   output logic               frame_err
);
   import sat_pkg::*;

   localparam int BITS_W = $clog2(DATA_W + 1);

   if (DATA_W < 32) begin : g_bad_width
      $error("DATA_W must hold the widest 32-bit word");
   end
   if (FRAME_W < 1) begin : g_bad_frame
      $error("FRAME_W must be at least 1");
   end

   sat_fmt_e          fmt;
   logic [BITS_W-1:0] word_bits;
   logic              dly, dual, sext;
   logic              slot_go, bit_act, word_end;
   logic [BITS_W-1:0] bit_idx;

   assign fmt       = sat_fmt_e'(cfg_format);
   assign word_bits = BITS_W'(wlen_to_bits(cfg_wlen));
   assign dly       = fmt_has_delay(fmt);
   assign dual      = fmt_stereo_capable(fmt) && (cfg_words_m1 == FRAME_W'(1));
   assign sext      = (fmt == FMT_LEFTJ);
   assign tx_ready  = slot_go;

   sat_frame_seq #(.BITS_W(BITS_W), .FRAME_W(FRAME_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .fsync     (fsync),
      .dual      (dual),
      .dly       (dly),
      .word_bits (word_bits),
      .words_m1  (cfg_words_m1),
      .slot_go   (slot_go),
      .bit_act   (bit_act),
      .word_end  (word_end),
      .bit_idx   (bit_idx),
      .frame_err (frame_err)
   );

   sat_tx_shift #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .slot_go   (slot_go),
      .bit_act   (bit_act),
      .bit_idx   (bit_idx),
      .word_bits (word_bits),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .sdout     (sdout),
      .underrun  (underrun)
   );

   sat_rx_shift #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_act   (bit_act),
      .word_end  (word_end),
      .sdin      (sdin),
      .sext      (sext),
      .word_bits (word_bits),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid)
   );

   // R7: the transmit handshake opens only on a tick
   p_ready_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> bit_tick) else $error("tx_ready off tick");

endmodule

// File: tb/test_sat_transceiver.sv
`timescale 1ns/1ps
module test_sat_transceiver;

   localparam int NT = 128;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_tick, fsync, sdin;
   logic [1:0]  cfg_format;
   logic [2:0]  cfg_wlen;
   logic [6:0]  cfg_words_m1;
   logic [31:0] tx_data;
   logic        tx_valid;
   logic        tx_ready, sdout, rx_valid, underrun, frame_err;
   logic [31:0] rx_data;

   always #2 clk = ~clk;

   sat_transceiver i_sat_transceiver (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync), .sdin(sdin),
      .cfg_format(cfg_format), .cfg_wlen(cfg_wlen), .cfg_words_m1(cfg_words_m1),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .sdout(sdout),
      .rx_data(rx_data), .rx_valid(rx_valid), .underrun(underrun), .frame_err(frame_err)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // per-tick stimulus and expectation tables
   bit fs_a [NT];
   bit sd_a [NT];
   bit exp_a[NT];
   bit ss_a [NT];
   bit we_a [NT];
   logic [31:0] txq[$];
   logic [31:0] rxq[$];
   string tag;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] fmt_rx(input logic [31:0] v, input int w, input bit sx);
      logic [31:0] r;
      for (int i = 0; i < 32; i++)
         r[i] = (i < w) ? v[i] : (sx & v[w-1]);
      return r;
   endfunction

   task automatic setup(input logic [1:0] f, input logic [2:0] wl, input logic [6:0] wm1,
                        input string t);
      tag = t;
      @(negedge clk);
      rst_n = 1'b0; bit_tick = 1'b0; fsync = 1'b0; sdin = 1'b0;
      tx_valid = 1'b0; tx_data = '0;
      cfg_format = f; cfg_wlen = wl; cfg_words_m1 = wm1;
      for (int i = 0; i < NT; i++) begin
         fs_a[i] = 0; sd_a[i] = 0; exp_a[i] = 0; ss_a[i] = 0; we_a[i] = 0;
      end
      txq.delete(); rxq.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_fs(input int a, input int b);
      for (int i = a; i <= b; i++) fs_a[i] = 1;
   endtask

   task automatic slot(input int st, input int w, input bit tx_on, input bit sx,
                       input logic [31:0] tv, input logic [31:0] rv);
      for (int j = 0; j < w; j++) begin
         exp_a[st+j] = tx_on ? tv[w-1-j] : 1'b0;
         sd_a[st+j]  = rv[w-1-j];
      end
      ss_a[st]     = 1;
      we_a[st+w-1] = 1;
      if (tx_on) txq.push_back(tv);
      rxq.push_back(fmt_rx(rv, w, sx));
   endtask

   task automatic play(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         fsync = fs_a[i]; sdin = sd_a[i]; bit_tick = 1'b1;
         if (txq.size() > 0) begin tx_valid = 1'b1; tx_data = txq[0]; end
         else begin tx_valid = 1'b0; tx_data = '0; end
         #1;
         chk(tx_ready == ss_a[i], {tag, "/R7"}, $sformatf("tx_ready tick %0d", i), tx_ready, ss_a[i]);
         if (tx_ready && tx_valid) void'(txq.pop_front());
         @(negedge clk);
         bit_tick = 1'b0;
         chk(sdout == exp_a[i], {tag, "/R2"}, $sformatf("sdout tick %0d", i), sdout, exp_a[i]);
         chk(rx_valid == we_a[i], {tag, "/R6"}, $sformatf("rx_valid tick %0d", i), rx_valid, we_a[i]);
         if (rx_valid && rxq.size() > 0) begin
            chk(rx_data == rxq[0], {tag, "/R6"}, $sformatf("rx_data tick %0d", i), rx_data, rxq[0]);
            void'(rxq.pop_front());
         end
         #1;
         chk(tx_ready == 1'b0, "R7", "tx_ready off tick", tx_ready, 0);
      end
   endtask

   task automatic finish_scn(input bit eu, input bit ef);
      chk(underrun == eu, {tag, "/R8"}, "underrun flag", underrun, eu);
      chk(frame_err == ef, {tag, "/R9"}, "frame_err flag", frame_err, ef);
      chk(rxq.size() == 0, tag, "rx words left over", rxq.size(), 0);
      chk(txq.size() == 0, tag, "tx words left over", txq.size(), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R11 reset state; then R4 single-phase DSP-B, four 16-bit words (code 2, R1)
      setup(2'd3, 3'd2, 7'd3, "R4");
      @(negedge clk);
      chk(sdout == 0,     "R11", "sdout after reset",     sdout, 0);
      chk(rx_valid == 0,  "R11", "rx_valid after reset",  rx_valid, 0);
      chk(rx_data == 0,   "R11", "rx_data after reset",   rx_data, 0);
      chk(underrun == 0,  "R11", "underrun after reset",  underrun, 0);
      chk(frame_err == 0, "R11", "frame_err after reset", frame_err, 0);
      fs_a[2] = 1;
      for (int k = 0; k < 4; k++)
         slot(2 + 16*k, 16, 1, 0, 32'hBEEF_0000 | (32'h1111 * (k+3)) | 32'h8000, 32'h5A00_93C6 ^ (k * 32'h2471));
      play(70);       // R10: ticks 0,1 and 66+ expect a low line
      finish_scn(0, 0);

      // R3 DSP-A delay, 12-bit words (code 1), second edge right after last bit (R9 legal)
      setup(2'd2, 3'd1, 7'd0, "R3");
      fs_a[2] = 1; fs_a[15] = 1;
      slot(3, 12, 1, 0, 32'hFFFF_FA53, 32'h0000_0C3A);
      slot(16, 12, 1, 0, 32'h0000_05AC, 32'h1234_5E81);
      play(32);
      finish_scn(0, 0);

      // R5 I2S stereo dual-phase, 16-bit, edges inside the final bit of each phase
      setup(2'd0, 3'd2, 7'd1, "R5");
      set_fs(1, 16); set_fs(33, 48);
      slot(2,  16, 1, 0, 32'h0000_C1A5, 32'h0000_F00D);
      slot(18, 16, 1, 0, 32'h7777_3E96, 32'h0000_8001);
      slot(34, 16, 1, 0, 32'h0000_9F03, 32'h0000_4C2B);
      slot(50, 16, 1, 0, 32'h0000_6AD7, 32'hFFFF_E718);
      play(70);
      finish_scn(0, 0);

      // R6 left-justified stereo, 24-bit (code 4), sign extension of negative sample
      setup(2'd1, 3'd4, 7'd1, "R6");
      set_fs(1, 24);
      slot(1,  24, 1, 1, 32'h00C3_5A0F, 32'h009A_5C31);
      slot(25, 24, 1, 1, 32'hAB81_2466, 32'h003C_0FF0);
      play(55);
      finish_scn(0, 0);

      // R5 boundary: I2S three channels stays single-phase; code 7 means 32 bits (R1)
      setup(2'd0, 3'd7, 7'd2, "R1/R5");
      set_fs(1, 48);
      slot(2,  32, 1, 0, 32'hF0E1_D2C3, 32'h8421_7BDE);
      slot(34, 32, 1, 0, 32'h1357_9BDF, 32'h0F0F_A5A5);
      slot(66, 32, 1, 0, 32'h8000_0001, 32'hC001_D00D);
      play(105);
      finish_scn(0, 0);

      // R8 underrun: DSP-B mono 20-bit (code 3), no transmit word offered
      setup(2'd3, 3'd3, 7'd0, "R8");
      fs_a[1] = 1;
      slot(1, 20, 0, 0, 32'h0, 32'h000F_3C96);
      play(26);
      finish_scn(1, 0);

      // R9 early edge: DSP-B two 8-bit words (code 0), restart at tick 5
      setup(2'd3, 3'd0, 7'd1, "R9");
      fs_a[1] = 1; fs_a[5] = 1;
      ss_a[1] = 1;
      for (int j = 0; j < 4; j++) exp_a[1+j] = (8'hD6 >> (7-j)) & 1'b1;
      txq.push_back(32'h0000_00D6);
      slot(5,  8, 1, 0, 32'h0000_0039, 32'h0000_00E4);
      slot(13, 8, 1, 0, 32'h0000_11A2, 32'h0000_005B);
      play(25);
      finish_scn(0, 1);

      // R1 code 5: DSP-B mono 32-bit
      setup(2'd3, 3'd5, 7'd0, "R1");
      fs_a[1] = 1;
      slot(1, 32, 1, 0, 32'hA1B2_C3D4, 32'h9E37_79B9);
      play(38);
      finish_scn(0, 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule